// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects interrupt events for a small microcontroller core and turns them into one request with a vector address. Some sources are external pins and the rest are internal event pulses, such as timer overflow or serial events. Each pin passes through a two-flop synchronizer. A per-pin polarity bit then picks the edge that raises its pending flag. Each internal source has its own pending flag, which a one-cycle event pulse sets.

A source can request service when its pending flag is set, its enable bit is 1 and the global enable is 1. Each source carries a priority bit that selects the high or the low level. Within a level, the lowest source index wins. The core answers a request with an acknowledge strobe. On acknowledge, the controller records the level now in service, and the core then jumps to the vector. A return strobe ends the most recent handler.

A handler at the high level blocks every request. A handler at the low level blocks all but high-level requests. Internal flags clear in hardware when their own source is acknowledged. Pin flags stay set until software clears them. The core keeps its own program-counter stack.

Top module: `intc_top`

## Requirements
- R1: A pin source's pending flag is set by a rising edge when its polarity bit is 1 and by a falling edge when it is 0. The opposite edge has no effect. The flag reads 1 three clock edges after the pin changes: two synchronizer stages, then the flag register.
- R2: A pin pending flag stays set until its clear strobe is applied, and the strobe clears it. If a qualifying edge and a clear arrive in the same cycle, the flag ends up set.
- R3: An internal pending flag is set by a one-cycle event pulse. An acknowledge of that same source clears it. An acknowledge of another source leaves it set.
- R4: A source can raise a request only when its pending flag is set, its enable bit is 1 and the global enable is 1.
- R5: The vector for source index i is 0x0003 + 8*i. With the default layout, source 0 is pin 0, source 1 is internal 0, source 2 is pin 1, source 3 is internal 1 and source 4 is internal 2.
- R6: With no handler in service, the winner is the lowest-index eligible source that has its priority bit set (1 = high). If no such source exists, the winner is the lowest-index eligible source.
- R7: While a low-level handler is in service, only high-level sources can request. While a high-level handler is in service, no source can request.
- R8: An acknowledge is accepted only while the request is high, and it marks the winner's level as in service. A return strobe clears the high level if it is in service, and otherwise clears the low level.
- R9: After reset, all pending flags, the request and both in-service flags are 0.
- R10: Acknowledging a pin source leaves its pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | NUM_EXT | Asynchronous external interrupt pins |
| ext_rise | input | NUM_EXT | Per-pin polarity: 1 = rising edge, 0 = falling edge |
| ext_clr | input | NUM_EXT | Software clear strobes for the pin pending flags |
| ext_pend | output | NUM_EXT | Pin pending flags |
| int_evt | input | NUM_INT | One-cycle internal event pulses |
| int_pend | output | NUM_INT | Internal pending flags |
| src_en | input | NUM_SRC | Per-source enable, indexed by source number |
| src_hi | input | NUM_SRC | Per-source priority level, 1 = high |
| glob_en | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | VEC_W | Vector address of the current winner |
| irq_ack | input | 1 | Core accepts the request |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| in_svc_hi | output | 1 | A high-level handler is in service |
| in_svc_lo | output | 1 | A low-level handler is in service |

## Verification
The checker enforces several rules on every cycle:
- a request needs the global enable;
- every vector has the 8-byte spacing;
- no request appears under a high-level handler, and only high-level sources request under a low-level handler;
- an accepted acknowledge always leaves a level in service, and a return clears the high level;
- pin flags hold unless cleared, and reset empties the flags.

Only the bench scenarios can show the rest:
- the choice of winner across all pending and priority patterns, against an arithmetic model;
- the exact three-edge latency of each pin polarity, and that the opposite edge is ignored;
- that an edge wins over a clear in the same cycle;
- that acknowledge clears only the internal flag of its own source;
- the preemption sequence.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int VEC_W    = 16;
    localparam int VEC_BASE = 3;
    localparam int VEC_STEP = 8;
    localparam int IDX_W    = 8;

    typedef struct packed {
        logic             valid;
        logic             hi;
        logic [IDX_W-1:0] idx;
    } grant_t;

    // number of set bits of m below position s
    function automatic int rank_below(logic [31:0] m, int s);
        int n;
        n = 0;
        for (int k = 0; k < 32; k++) begin
            if (k < s && m[k]) n++;
        end
        return n;
    endfunction

    function automatic int count_ones(logic [31:0] m, int width);
        return rank_below(m, width);
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(logic [IDX_W-1:0] idx);
        return VEC_W'(VEC_BASE + VEC_STEP * int'(idx));
    endfunction

endpackage

// File: rtl/intc_ext_edge.sv
module intc_ext_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_sel,
    input  logic clr,
    output logic pend
);
    logic s1, s2, prev;
    logic hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= pin;
            s2   <= s1;
            prev <= s2;
        end
    end

    always_comb begin
        if (rise_sel) hit = s2 & ~prev;
        else          hit = ~s2 & prev;
    end

    always_ff @(posedge clk) begin
        if (rst)      pend <= 1'b0;
        else if (hit) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
    end
endmodule

// File: rtl/intc_int_flag.sv
module intc_int_flag (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic ack_hit,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)          pend <= 1'b0;
        else if (evt)     pend <= 1'b1;
        else if (ack_hit) pend <= 1'b0;
    end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 5
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] hi,
    input  logic               glob_en,
    input  logic               svc_hi,
    input  logic               svc_lo,
    output grant_t             grant
);
    logic [NUM_SRC-1:0] elig;
    logic               hv, lv;
    logic [IDX_W-1:0]   hidx, lidx;

    assign elig = glob_en ? (pend & en) : '0;

    always_comb begin
        hv   = 1'b0;
        lv   = 1'b0;
        hidx = '0;
        lidx = '0;
        // descending scan: the lowest index is written last and wins
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i] && hi[i]) begin
                hv   = 1'b1;
                hidx = IDX_W'(i);
            end
            if (elig[i] && !hi[i]) begin
                lv   = 1'b1;
                lidx = IDX_W'(i);
            end
        end
        grant = '0;
        if (hv) begin
            grant.valid = ~svc_hi;
            grant.hi    = 1'b1;
            grant.idx   = hidx;
        end else if (lv) begin
            grant.valid = ~svc_hi & ~svc_lo;
            grant.hi    = 1'b0;
            grant.idx   = lidx;
        end
    end
endmodule

// File: rtl/intc_level_track.sv
module intc_level_track (
    input  logic clk,
    input  logic rst,
    input  logic take_hi,
    input  logic take_lo,
    input  logic ret,
    output logic svc_hi,
    output logic svc_lo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            svc_hi <= 1'b0;
            svc_lo <= 1'b0;
        end else begin
            if (take_hi)     svc_hi <= 1'b1;
            else if (ret && svc_hi) svc_hi <= 1'b0;
            if (take_lo)     svc_lo <= 1'b1;
            else if (ret && !svc_hi) svc_lo <= 1'b0;
        end
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int          NUM_SRC  = 5,
    parameter logic [31:0] EXT_MASK = 32'h0000_0005,
    localparam int         NUM_EXT  = count_ones(EXT_MASK, NUM_SRC),
    localparam int         NUM_INT  = NUM_SRC - NUM_EXT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXT-1:0] ext_pin,
    input  logic [NUM_EXT-1:0] ext_rise,
    input  logic [NUM_EXT-1:0] ext_clr,
    output logic [NUM_EXT-1:0] ext_pend,
    input  logic [NUM_INT-1:0] int_evt,
    output logic [NUM_INT-1:0] int_pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_hi,
    input  logic               glob_en,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic               in_svc_hi,
    output logic               in_svc_lo
);
    logic [NUM_SRC-1:0] pend_all;
    logic [NUM_SRC-1:0] ack_hot;
    grant_t             grant;
    logic               accept;

    assign accept = irq_ack & grant.valid;

    always_comb begin
        ack_hot = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (accept && grant.idx == IDX_W'(i)) ack_hot[i] = 1'b1;
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        if (EXT_MASK[s]) begin : g_ext
            localparam int E = rank_below(EXT_MASK, s);
            intc_ext_edge u_edge (
                .clk      (clk),
                .rst      (rst),
                .pin      (ext_pin[E]),
                .rise_sel (ext_rise[E]),
                .clr      (ext_clr[E]),
                .pend     (ext_pend[E])
            );
            assign pend_all[s] = ext_pend[E];
        end else begin : g_int
            localparam int K = s - rank_below(EXT_MASK, s);
            intc_int_flag u_flag (
                .clk     (clk),
                .rst     (rst),
                .evt     (int_evt[K]),
                .ack_hit (ack_hot[s]),
                .pend    (int_pend[K])
            );
            assign pend_all[s] = int_pend[K];
        end
    end

    intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend    (pend_all),
        .en      (src_en),
        .hi      (src_hi),
        .glob_en (glob_en),
        .svc_hi  (in_svc_hi),
        .svc_lo  (in_svc_lo),
        .grant   (grant)
    );

    intc_level_track u_lvl (
        .clk     (clk),
        .rst     (rst),
        .take_hi (accept & grant.hi),
        .take_lo (accept & ~grant.hi),
        .ret     (irq_ret),
        .svc_hi  (in_svc_hi),
        .svc_lo  (in_svc_lo)
    );

    assign irq_req = grant.valid;
    assign irq_vec = vec_of(grant.idx);
endmodule

// File: rtl/intc_check.sv
module intc_check
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 5,
    parameter int NUM_EXT = 2
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_EXT-1:0] ext_clr,
    input logic [NUM_EXT-1:0] ext_pend,
    input logic [NUM_SRC-1:0] src_hi,
    input logic               glob_en,
    input logic               irq_req,
    input logic [VEC_W-1:0]   irq_vec,
    input logic               irq_ack,
    input logic               irq_ret,
    input logic               in_svc_hi,
    input logic               in_svc_lo
);
    localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic win_hi;
    assign win_hi = |((src_hi >> irq_vec[IW+2:3]) & NUM_SRC'(1));

    p_req_glob_r4: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> glob_en);

    p_vec_spacing_r5: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec[2:0] == 3'd3));

    p_hi_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        in_svc_hi |-> !irq_req);

    p_lo_only_hi_r7: assert property (@(posedge clk) disable iff (rst)
        (in_svc_lo && irq_req) |-> win_hi);

    p_ack_marks_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && !irq_ret) |=> (in_svc_hi || in_svc_lo));

    p_ret_hi_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_ret && in_svc_hi && !irq_ack) |=> !in_svc_hi);

    p_pin_hold_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ext_pend & $past(ext_pend & ~ext_clr)) == $past(ext_pend & ~ext_clr)));

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (ext_pend == '0 && !in_svc_hi && !in_svc_lo));
endmodule

bind intc_top intc_check #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_clr   (ext_clr),
    .ext_pend  (ext_pend),
    .src_hi    (src_hi),
    .glob_en   (glob_en),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .in_svc_hi (in_svc_hi),
    .in_svc_lo (in_svc_lo)
);

// File: tb/test_intc_top.sv
module test_intc_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  ext_pin, ext_rise, ext_clr, ext_pend;
    logic [2:0]  int_evt, int_pend;
    logic [4:0]  src_en, src_hi;
    logic        glob_en, irq_req, irq_ack, irq_ret, in_svc_hi, in_svc_lo;
    logic [15:0] irq_vec;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    intc_top i_intc_top (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // internal bit k maps to source index 1, 3, 4
    function automatic int int_src(input int k);
        return (k == 0) ? 1 : (k == 1) ? 3 : 4;
    endfunction

    function automatic int src_int(input int s);
        return (s == 1) ? 0 : (s == 3) ? 1 : 2;
    endfunction

    function automatic int pick(input logic [4:0] p, input logic [4:0] h);
        for (int i = 0; i < 5; i++) if (p[i] && h[i]) return i;
        for (int i = 0; i < 5; i++) if (p[i]) return i;
        return -1;
    endfunction

    task automatic pulse_int(input logic [2:0] m);
        int_evt = m; cyc(1); int_evt = '0;
    endtask

    task automatic do_ack;
        irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
    endtask

    task automatic do_ret;
        irq_ret = 1'b1; cyc(1); irq_ret = 1'b0;
    endtask

    task automatic drain;
        for (int k = 0; k < 4; k++) if (irq_req) begin do_ack; do_ret; end
    endtask

    initial begin
        int cnt = 0;
        while (!done && cnt < 150000) begin @(posedge clk); cnt++; end
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cnt, 0);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1; ext_pin = '0; ext_rise = '0; ext_clr = '0; int_evt = '0;
        src_en = '0; src_hi = '0; glob_en = 0; irq_ack = 0; irq_ret = 0;
        cyc(3); rst = 0; cyc(1);

        // R9 reset state
        chk(ext_pend == 0 && int_pend == 0, "R9 flags", {ext_pend, int_pend}, 0);
        chk(!irq_req && !in_svc_hi && !in_svc_lo, "R9 req/svc",
            {irq_req, in_svc_hi, in_svc_lo}, 0);

        // R4: pending internal source blocked by enables
        pulse_int(3'b001);
        chk(int_pend == 3'b001, "R3 set by pulse", int_pend, 1);
        chk(!irq_req, "R4 no glob no en", irq_req, 0);
        src_en = 5'b00010; cyc(1);
        chk(!irq_req, "R4 glob off", irq_req, 0);
        glob_en = 1; src_en = 5'b00000; cyc(1);
        chk(!irq_req, "R4 src off", irq_req, 0);
        src_en = 5'b11010; cyc(1);
        chk(irq_req && irq_vec == 16'h000B, "R4 R5 enabled req", irq_vec, 16'h000B);
        // R8: acknowledge with request low is ignored
        glob_en = 0; do_ack;
        chk(!in_svc_lo && !in_svc_hi && int_pend == 3'b001, "R8 ack w/o req",
            {in_svc_hi, in_svc_lo, int_pend}, 1);
        glob_en = 1; drain;

        // R5 R6 R3 sweep over internal pending patterns and priority masks
        for (int m = 1; m < 8; m++) begin
            for (int h = 0; h < 32; h++) begin
                logic [4:0] p5;
                int w;
                p5 = '0;
                for (int k = 0; k < 3; k++) if (m[k]) p5[int_src(k)] = 1'b1;
                src_hi = 5'(h);
                pulse_int(3'(m));
                w = pick(p5, 5'(h));
                chk(irq_req && irq_vec == 16'(3 + 8 * w), "R5 R6 winner vector",
                    irq_vec, 3 + 8 * w);
                do_ack;
                chk(int_pend == (3'(m) & ~(3'b001 << src_int(w))), "R3 ack clears own only",
                    int_pend, 3'(m) & ~(3'b001 << src_int(w)));
                chk(in_svc_hi == src_hi[w] && in_svc_lo == !src_hi[w], "R8 level marked",
                    {in_svc_hi, in_svc_lo}, {src_hi[w], !src_hi[w]});
                do_ret;
                chk(!in_svc_hi && !in_svc_lo, "R8 ret clears", {in_svc_hi, in_svc_lo}, 0);
                drain;
            end
        end

        // R7 preemption sequence
        src_hi = 5'b00000;
        pulse_int(3'b001); do_ack;
        chk(in_svc_lo, "R7 lo in service", in_svc_lo, 1);
        pulse_int(3'b010);
        chk(!irq_req, "R7 lo cannot preempt lo", irq_req, 0);
        src_hi = 5'b10000; pulse_int(3'b100);
        chk(irq_req && irq_vec == 16'h0023, "R7 hi preempts lo", irq_vec, 16'h0023);
        do_ack;
        chk(in_svc_hi && in_svc_lo, "R7 nested", {in_svc_hi, in_svc_lo}, 3);
        src_hi = 5'b11000; cyc(1);
        chk(!irq_req, "R7 hi cannot preempt hi", irq_req, 0);
        do_ret;
        chk(!in_svc_hi && in_svc_lo, "R8 ret clears hi first", {in_svc_hi, in_svc_lo}, 1);
        chk(irq_req && irq_vec == 16'h001B, "R7 hi under lo", irq_vec, 16'h001B);
        do_ack; do_ret; do_ret;
        chk(!in_svc_hi && !in_svc_lo, "R8 all returned", {in_svc_hi, in_svc_lo}, 0);
        src_hi = '0; drain;

        // R1 R2 R10 pin sources, both pins and polarities
        src_en = '0;
        for (int e = 0; e < 2; e++) begin
            for (int pol = 0; pol < 2; pol++) begin
                int sidx;
                sidx = (e == 0) ? 0 : 2;
                ext_rise[e] = 1'(pol);
                ext_pin[e] = 1'(pol); cyc(4);
                ext_clr[e] = 1; cyc(1); ext_clr[e] = 0;
                chk(!ext_pend[e], "R2 clear strobe", ext_pend[e], 0);
                ext_pin[e] = !1'(pol); cyc(4);
                chk(!ext_pend[e], "R1 opposite edge ignored", ext_pend[e], 0);
                ext_pin[e] = 1'(pol); cyc(2);
                chk(!ext_pend[e], "R1 not before third edge", ext_pend[e], 0);
                cyc(1);
                chk(ext_pend[e], "R1 set on third edge", ext_pend[e], 1);
                cyc(3);
                chk(ext_pend[e], "R2 holds", ext_pend[e], 1);
                src_en[sidx] = 1; cyc(1);
                chk(irq_req && irq_vec == 16'(3 + 8 * sidx), "R5 pin vector",
                    irq_vec, 3 + 8 * sidx);
                do_ack;
                chk(ext_pend[e], "R10 ack keeps pin flag", ext_pend[e], 1);
                do_ret;
                src_en[sidx] = 0;
                ext_clr[e] = 1; cyc(1); ext_clr[e] = 0;
                chk(!ext_pend[e], "R2 cleared", ext_pend[e], 0);
                // edge and clear in the same cycle
                ext_pin[e] = !1'(pol); cyc(4);
                ext_pin[e] = 1'(pol); cyc(2);
                ext_clr[e] = 1; cyc(1); ext_clr[e] = 0;
                chk(ext_pend[e], "R2 edge beats clear", ext_pend[e], 1);
                ext_clr[e] = 1; cyc(1); ext_clr[e] = 0;
            end
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule